// File: doc/BRIEF.md
# Interrupt Pin Trigger and End-of-Interrupt Engine

This block sits between the external interrupt pins of an I/O interrupt router and the message path to the local interrupt controllers. Each pin has a redirection entry that the block receives as a set of configuration inputs: vector, polarity, trigger mode, mask, destination and destination mode. For every pin the block keeps a request bit, which follows the pin's effective level, and a remote-IRR bit. It decides when a pin needs service and sends one delivery request per grant over a valid/ready handshake.

Edge-triggered pins are serviced once for each rising edge of their effective level. Level-triggered pins are serviced while their effective level is high and their remote-IRR bit is clear. The remote-IRR bit is then set, and it stays set until an end-of-interrupt message carrying the pin's vector arrives. If the pin is still asserted when that message clears the bit, the pin is serviced again. A delivery for pin 0 always goes to the boot processor in physical destination mode.

The register interface that programs the entries and the local controllers that consume the deliveries are outside this block.

Top module: `irq_route_engine`

## Requirements
- R1: While `rst` is high, and in the cycles after it that have no new pin activity, `dlv_valid` is 0. Reset clears every request, remote-IRR and pending bit.
- R2: The effective level of pin i is `pin_raw[i] ^ cfg_polarity[i]`. With polarity 1, a falling raw input is a rising effective edge.
- R3: An edge pin (`cfg_level[i]`=0) is delivered exactly once for each 0-to-1 change of its effective level. Holding the level high brings no further deliveries.
- R4: A level pin (`cfg_level[i]`=1) with its effective level high and remote IRR clear is delivered once. Its remote IRR is set when it is granted, and this blocks further deliveries.
- R5: An EOI (`eoi_valid` with `eoi_vector`) clears remote IRR on every level pin whose `cfg_vector` equals the EOI vector. A pin that is still asserted is then delivered again. An EOI whose vector matches no level pin changes nothing.
- R6: A masked pin (`cfg_mask[i]`=1) is never delivered. Masking a pin discards its pending service. Unmasking a pin whose level is already high brings no delivery for an edge pin.
- R7: A level pin whose effective level falls before it is granted loses its pending service and is not delivered.
- R8: When several pins are pending, the lowest-numbered unmasked pin is granted first. At most one delivery is loaded per cycle.
- R9: While `dlv_valid`=1 and `dlv_ready`=0, the output stays valid and its contents stay stable. A pin that becomes pending meanwhile is kept until the output can accept it.
- R10: A delivery for pin 0 carries `dlv_dest` = `bsp_id` and `dlv_dest_logical` = 0, whatever its entry says.
- R11: A rising effective edge driven before clock edge k sets the pending bit at edge k. The delivery appears on the output at edge k+1 if the output is free.
- R12: A delivery carries the granted pin's index, its `cfg_vector`, its `cfg_dest` and destination mode (`cfg_dest_logical`, 1 = logical), and its trigger mode (`dlv_level`, 1 = level). These are taken at grant time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NUM_PINS | Raw interrupt pin levels |
| cfg_polarity | input | NUM_PINS | 1 = pin is active low |
| cfg_level | input | NUM_PINS | Trigger mode per pin, 1 = level, 0 = edge |
| cfg_mask | input | NUM_PINS | 1 = pin masked |
| cfg_vector | input | NUM_PINS*VEC_W | Vector per pin, pin i in bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NUM_PINS*DEST_W | Destination per pin, packed like cfg_vector |
| cfg_dest_logical | input | NUM_PINS | Destination mode per pin, 1 = logical |
| bsp_id | input | DEST_W | Boot processor ID used for pin 0 |
| eoi_valid | input | 1 | End-of-interrupt message strobe, one cycle |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Downstream accepts the delivery |
| dlv_pin | output | PIN_W | Index of the delivered pin |
| dlv_vector | output | VEC_W | Delivered vector |
| dlv_dest | output | DEST_W | Destination ID |
| dlv_dest_logical | output | 1 | Destination mode, 1 = logical |
| dlv_level | output | 1 | Trigger mode of the delivery, 1 = level |

## Verification
The hardest situation to reach is a pin that becomes pending while the output register is held by an earlier, unaccepted delivery. Only in that window can a later mask or a falling level cancel the pending service before it is granted. The bench first holds `dlv_ready` low and raises an edge pin so that its delivery fills the output. It then raises the victim pin and masks it, or drops it, while the stall lasts. Only after that does it release `dlv_ready`, and it counts the deliveries accepted per pin. EOI re-delivery is reached by holding a level pin high across an EOI for its shared vector, while a masked level pin with the same vector shows that the mask still gates it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  typedef enum logic {
    DMODE_PHYS    = 1'b0,
    DMODE_LOGICAL = 1'b1
  } dmode_e;
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       pin_raw,
  input  logic [NUM_PINS-1:0]       cfg_polarity,
  input  logic [NUM_PINS-1:0]       cfg_level,
  input  logic [NUM_PINS-1:0]       cfg_mask,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS-1:0]       grant_oh,
  output logic [NUM_PINS-1:0]       pend_q,
  output logic [NUM_PINS-1:0]       rirr_q,
  output logic [NUM_PINS-1:0]       req_q
);
  import irq_route_pkg::*;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic eff_lvl;
    logic is_level;
    logic eoi_hit;
    logic edge_set;
    logic level_set;
    logic drop;
    logic pend_d;
    logic rirr_d;

    always_comb begin
      eff_lvl   = pin_raw[g] ^ cfg_polarity[g];
      is_level  = (trig_e'(cfg_level[g]) == TRIG_LEVEL);
      eoi_hit   = eoi_valid && is_level &&
                  (eoi_vector == cfg_vector[g*VEC_W +: VEC_W]);
      edge_set  = !is_level && eff_lvl && !req_q[g];
      level_set = is_level && eff_lvl && !rirr_q[g] && !grant_oh[g];
      drop      = cfg_mask[g] || (is_level && !eff_lvl);
      pend_d    = (edge_set || level_set || (pend_q[g] && !grant_oh[g])) && !drop;
      if (grant_oh[g] && is_level)
        rirr_d = 1'b1;
      else if (eoi_hit)
        rirr_d = 1'b0;
      else
        rirr_d = rirr_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
        rirr_q[g] <= 1'b0;
      end else begin
        req_q[g]  <= eff_lvl;
        pend_q[g] <= pend_d;
        rirr_q[g] <= rirr_d;
      end
    end
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_PINS = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] cand,
  output logic                any,
  output logic [PIN_W-1:0]    idx,
  output logic [NUM_PINS-1:0] oh
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    oh  = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (cand[i] && !any) begin
        any   = 1'b1;
        idx   = PIN_W'(i);
        oh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_dlv_stage.sv
module irq_dlv_stage #(
  parameter int PIN_W  = 3,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              load_any,
  input  logic [PIN_W-1:0]  in_pin,
  input  logic [VEC_W-1:0]  in_vector,
  input  logic [DEST_W-1:0] in_dest,
  input  logic              in_dest_logical,
  input  logic              in_level,
  output logic              dlv_valid,
  output logic [PIN_W-1:0]  dlv_pin,
  output logic [VEC_W-1:0]  dlv_vector,
  output logic [DEST_W-1:0] dlv_dest,
  output logic              dlv_dest_logical,
  output logic              dlv_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid        <= 1'b0;
      dlv_pin          <= '0;
      dlv_vector       <= '0;
      dlv_dest         <= '0;
      dlv_dest_logical <= 1'b0;
      dlv_level        <= 1'b0;
    end else if (load_en) begin
      dlv_valid <= load_any;
      if (load_any) begin
        dlv_pin          <= in_pin;
        dlv_vector       <= in_vector;
        dlv_dest         <= in_dest;
        dlv_dest_logical <= in_dest_logical;
        dlv_level        <= in_level;
      end
    end
  end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        pin_raw,
  input  logic [NUM_PINS-1:0]        cfg_polarity,
  input  logic [NUM_PINS-1:0]        cfg_level,
  input  logic [NUM_PINS-1:0]        cfg_mask,
  input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector,
  input  logic [NUM_PINS*DEST_W-1:0] cfg_dest,
  input  logic [NUM_PINS-1:0]        cfg_dest_logical,
  input  logic [DEST_W-1:0]          bsp_id,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vector,
  output logic                       dlv_valid,
  input  logic                       dlv_ready,
  output logic [PIN_W-1:0]           dlv_pin,
  output logic [VEC_W-1:0]           dlv_vector,
  output logic [DEST_W-1:0]          dlv_dest,
  output logic                       dlv_dest_logical,
  output logic                       dlv_level
);
  import irq_route_pkg::*;

  logic [NUM_PINS-1:0] pend_q;
  logic [NUM_PINS-1:0] rirr_q;
  logic [NUM_PINS-1:0] req_q;
  logic [NUM_PINS-1:0] eligible;
  logic [NUM_PINS-1:0] pick_oh;
  logic [NUM_PINS-1:0] grant_oh;
  logic                pick_any;
  logic [PIN_W-1:0]    pick_idx;
  logic                can_load;
  logic [DEST_W-1:0]   sel_dest;
  logic                sel_logical;

  assign eligible = pend_q & ~cfg_mask;
  assign can_load = !dlv_valid || dlv_ready;
  assign grant_oh = can_load ? pick_oh : '0;

  always_comb begin
    if (pick_idx == '0) begin
      sel_dest    = bsp_id;
      sel_logical = DMODE_PHYS;
    end else begin
      sel_dest    = cfg_dest[pick_idx*DEST_W +: DEST_W];
      sel_logical = cfg_dest_logical[pick_idx];
    end
  end

  irq_pin_track #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_track (
    .clk          (clk),
    .rst          (rst),
    .pin_raw      (pin_raw),
    .cfg_polarity (cfg_polarity),
    .cfg_level    (cfg_level),
    .cfg_mask     (cfg_mask),
    .cfg_vector   (cfg_vector),
    .eoi_valid    (eoi_valid),
    .eoi_vector   (eoi_vector),
    .grant_oh     (grant_oh),
    .pend_q       (pend_q),
    .rirr_q       (rirr_q),
    .req_q        (req_q)
  );

  irq_lowest_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .cand (eligible),
    .any  (pick_any),
    .idx  (pick_idx),
    .oh   (pick_oh)
  );

  irq_dlv_stage #(.PIN_W(PIN_W), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_stage (
    .clk              (clk),
    .rst              (rst),
    .load_en          (can_load),
    .load_any         (pick_any),
    .in_pin           (pick_idx),
    .in_vector        (cfg_vector[pick_idx*VEC_W +: VEC_W]),
    .in_dest          (sel_dest),
    .in_dest_logical  (sel_logical),
    .in_level         (cfg_level[pick_idx]),
    .dlv_valid        (dlv_valid),
    .dlv_pin          (dlv_pin),
    .dlv_vector       (dlv_vector),
    .dlv_dest         (dlv_dest),
    .dlv_dest_logical (dlv_dest_logical),
    .dlv_level        (dlv_level)
  );
endmodule

// File: rtl/irq_route_engine_chk.sv
module irq_route_engine_chk #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int PIN_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic [PIN_W-1:0]    dlv_pin,
  input logic [VEC_W-1:0]    dlv_vector,
  input logic [DEST_W-1:0]   dlv_dest,
  input logic                dlv_dest_logical,
  input logic [DEST_W-1:0]   bsp_id,
  input logic [NUM_PINS-1:0] cfg_level,
  input logic [NUM_PINS-1:0] cfg_mask,
  input logic [NUM_PINS-1:0] rirr_q,
  input logic [NUM_PINS-1:0] grant_oh
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !dlv_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin) &&
                                $stable(dlv_vector) && $stable(dlv_dest));

  a_r10_pin0_bsp: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && dlv_pin == '0 |-> !dlv_dest_logical && dlv_dest == bsp_id);

  a_r4_level_gated: assert property (@(posedge clk) disable iff (rst)
    (grant_oh & cfg_level & rirr_q) == '0);

  a_r6_no_masked_grant: assert property (@(posedge clk) disable iff (rst)
    (grant_oh & cfg_mask) == '0);

  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_oh));
endmodule

bind irq_route_engine irq_route_engine_chk #(
  .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .PIN_W(PIN_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .dlv_valid        (dlv_valid),
  .dlv_ready        (dlv_ready),
  .dlv_pin          (dlv_pin),
  .dlv_vector       (dlv_vector),
  .dlv_dest         (dlv_dest),
  .dlv_dest_logical (dlv_dest_logical),
  .bsp_id           (bsp_id),
  .cfg_level        (cfg_level),
  .cfg_mask         (cfg_mask),
  .rirr_q           (rirr_q),
  .grant_oh         (grant_oh)
);

// File: tb/irq_route_engine_bench.sv
module irq_route_engine_bench;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  raw, pol, lvl, msk, dlog;
  logic [N*VW-1:0] vec;
  logic [N*DW-1:0] dst;
  logic [DW-1:0] bsp = 8'hA5;
  logic          eoi_v = 1'b0;
  logic [VW-1:0] eoi_vec = '0;
  logic          rdy = 1'b1;
  logic          dlv_valid, dlv_dest_logical, dlv_level;
  logic [PW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [DW-1:0] dlv_dest;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int cnt [N];
  int order[$];
  int last_vec [N];
  int last_dst [N];
  int last_log [N];
  int last_lvl [N];

  bit m_req [N];
  bit m_rirr[N];
  bit m_pend[N];
  bit m_valid;
  int m_pin, m_vec, m_dst, m_log, m_lvl;

  always #4 clk = ~clk;

  irq_route_engine #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW)) u_irq_route_engine (
    .clk(clk), .rst(rst), .pin_raw(raw), .cfg_polarity(pol), .cfg_level(lvl),
    .cfg_mask(msk), .cfg_vector(vec), .cfg_dest(dst), .cfg_dest_logical(dlog),
    .bsp_id(bsp), .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
    .dlv_valid(dlv_valid), .dlv_ready(rdy), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_dest_logical(dlv_dest_logical), .dlv_level(dlv_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_req[i] = 0; m_rirr[i] = 0; m_pend[i] = 0;
      end
      m_valid = 0;
    end else begin
      bit free;
      int win;
      bit eff;
      free = !m_valid || rdy;
      win = -1;
      for (int i = N - 1; i >= 0; i--)
        if (m_pend[i] && !msk[i]) win = i;
      if (!free) win = -1;
      for (int i = 0; i < N; i++) begin
        bit g, newreq, keep;
        eff = raw[i] ^ pol[i];
        g = (win == i);
        if (lvl[i]) newreq = eff && !m_rirr[i] && !g;
        else        newreq = eff && !m_req[i];
        keep = m_pend[i] && !g;
        m_pend[i] = (newreq || keep) && !msk[i] && !(lvl[i] && !eff);
        if (g && lvl[i]) m_rirr[i] = 1;
        else if (eoi_v && lvl[i] && eoi_vec == vec[i*VW +: VW]) m_rirr[i] = 0;
        m_req[i] = eff;
      end
      if (free) begin
        m_valid = (win >= 0);
        if (win >= 0) begin
          m_pin = win;
          m_vec = vec[win*VW +: VW];
          m_dst = (win == 0) ? bsp : dst[win*DW +: DW];
          m_log = (win == 0) ? 0 : dlog[win];
          m_lvl = lvl[win];
        end
      end
    end
  end

  // acceptance log
  always @(posedge clk) begin
    if (!rst && dlv_valid && rdy) begin
      cnt[dlv_pin]++;
      order.push_back(dlv_pin);
      last_vec[dlv_pin] = dlv_vector;
      last_dst[dlv_pin] = dlv_dest;
      last_log[dlv_pin] = dlv_dest_logical;
      last_lvl[dlv_pin] = dlv_level;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk(dlv_valid == m_valid, "R9 valid", dlv_valid, m_valid);
      if (m_valid && dlv_valid) begin
        chk(dlv_pin == m_pin, "R8 pin", dlv_pin, m_pin);
        chk(dlv_vector == m_vec && dlv_level == m_lvl, "R12 vector/trigger",
            {dlv_vector, 7'd0, dlv_level}, {m_vec[7:0], 7'd0, m_lvl[0]});
        chk(dlv_dest == m_dst && dlv_dest_logical == m_log, "R12 destination",
            {dlv_dest, 7'd0, dlv_dest_logical}, {m_dst[7:0], 7'd0, m_log[0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int mark;
    for (int i = 0; i < N; i++) begin
      cnt[i] = 0;
      vec[i*VW +: VW] = VW'(8'h30 + i);
      dst[i*DW +: DW] = DW'(8'h10 + i);
    end
    vec[3*VW +: VW] = 8'h40;
    vec[4*VW +: VW] = 8'h40;
    pol  = 8'b0000_0100;
    lvl  = 8'b1001_1000;
    msk  = 8'b0011_0000;
    dlog = 8'hFF;
    raw  = pol;
    step(2);
    chk(dlv_valid == 0, "R1 idle in reset", dlv_valid, 0);
    step(2);
    rst = 1'b0;
    step(3);
    chk(dlv_valid == 0 && order.size() == 0, "R1 idle after reset", order.size(), 0);

    // R11 latency and R10 pin 0 steering
    raw[0] = 1'b1;
    step(1);
    chk(dlv_valid == 0, "R11 not yet valid", dlv_valid, 0);
    step(1);
    chk(dlv_valid == 1 && dlv_pin == 0, "R11 valid after two edges", dlv_pin, 0);
    chk(dlv_dest == 8'hA5 && dlv_dest_logical == 0, "R10 boot processor", dlv_dest, 8'hA5);
    step(6);
    chk(cnt[0] == 1, "R3 held high gives one delivery", cnt[0], 1);
    raw[0] = 1'b0; step(2); raw[0] = 1'b1; step(4);
    chk(cnt[0] == 2, "R3 second rise", cnt[0], 2);

    // R12 fields for a plain edge pin
    raw[1] = 1'b1; step(4);
    chk(cnt[1] == 1, "R3 pin1 delivered", cnt[1], 1);
    chk(last_vec[1] == 8'h31 && last_dst[1] == 8'h11, "R12 pin1 vector/dest",
        {last_vec[1][7:0], last_dst[1][7:0]}, 16'h3111);
    chk(last_log[1] == 1 && last_lvl[1] == 0, "R12 pin1 modes",
        {last_log[1][0], last_lvl[1][0]}, 2'b10);

    // R2 active-low pin
    raw[2] = 1'b0; step(4);
    chk(cnt[2] == 1, "R2 falling raw is a rise", cnt[2], 1);
    raw[2] = 1'b1; step(3);
    chk(cnt[2] == 1, "R2 rising raw is a fall", cnt[2], 1);

    // R4 level gating; pin4 shares the vector but is masked
    raw[3] = 1'b1; raw[4] = 1'b1; step(10);
    chk(cnt[3] == 1, "R4 one delivery while held", cnt[3], 1);
    chk(last_lvl[3] == 1, "R12 level trigger", last_lvl[3], 1);

    // R5 end of interrupt
    eoi_v = 1'b1; eoi_vec = 8'h55; step(1); eoi_v = 1'b0; step(6);
    chk(cnt[3] == 1, "R5 unmatched EOI ignored", cnt[3], 1);
    eoi_v = 1'b1; eoi_vec = 8'h40; step(1); eoi_v = 1'b0; step(6);
    chk(cnt[3] == 2, "R5 matched EOI redelivers", cnt[3], 2);
    chk(cnt[4] == 0, "R6 masked level pin stays silent", cnt[4], 0);
    raw[3] = 1'b0; step(2);
    eoi_v = 1'b1; step(1); eoi_v = 1'b0; step(6);
    chk(cnt[3] == 2, "R5 EOI with pin low", cnt[3], 2);
    raw[3] = 1'b1; step(4);
    chk(cnt[3] == 3, "R5 remote IRR was cleared", cnt[3], 3);

    // R6 masked edge pin, then unmasked while high
    raw[5] = 1'b1; step(4);
    chk(cnt[5] == 0, "R6 masked edge", cnt[5], 0);
    msk[5] = 1'b0; step(4);
    chk(cnt[5] == 0, "R6 unmask while high", cnt[5], 0);

    // R9 stall, R6 mask discards pending service
    raw[1] = 1'b0; step(2);
    rdy = 1'b0; raw[1] = 1'b1; step(3);
    chk(dlv_valid == 1 && dlv_pin == 1, "R9 held under stall", dlv_pin, 1);
    raw[6] = 1'b1; step(2);
    msk[6] = 1'b1; step(2);
    msk[6] = 1'b0; step(1);
    chk(dlv_valid == 1 && dlv_pin == 1, "R9 still held", dlv_pin, 1);
    rdy = 1'b1; step(6);
    chk(cnt[6] == 0, "R6 masked while pending", cnt[6], 0);
    chk(cnt[1] == 2, "R9 stalled delivery accepted once", cnt[1], 2);

    // R7 level pin drops before grant
    raw[1] = 1'b0; step(2);
    rdy = 1'b0; raw[1] = 1'b1; step(3);
    raw[7] = 1'b1; step(2);
    raw[7] = 1'b0; step(2);
    rdy = 1'b1; step(6);
    chk(cnt[7] == 0, "R7 dropped level pin", cnt[7], 0);

    // R8 priority of simultaneous requests
    raw[1] = 1'b0; raw[6] = 1'b0; step(2);
    mark = order.size();
    raw[1] = 1'b1; raw[6] = 1'b1; step(6);
    chk(order.size() == mark + 2, "R8 both delivered", order.size(), mark + 2);
    if (order.size() == mark + 2) begin
      chk(order[mark] == 1, "R8 lowest first", order[mark], 1);
      chk(order[mark+1] == 6, "R8 then next", order[mark+1], 6);
    end

    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule